// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps wall-clock time and the calendar date as a chain of counters. A reference enable at 32768 Hz goes into a prescaler, which produces one tick per second. Each tick advances the seconds, and carries ripple on through minutes, hours, day of week, day of month, month, year and century. Every field except the century is held in packed BCD. Hours run on a 24-hour dial. The length of each month is chosen automatically, and that includes February in leap years. The century is a plain binary byte.

A surrounding register interface writes all fields together through a single load strobe. The same strobe restarts the sub-second prescaler, so the first second after a load always has its full length. A one-cycle pulse marks every edge at which the fields have just advanced, and a shadow register window can use that pulse to copy a consistent snapshot. A halt input freezes the prescaler. A signed trim value lengthens or shortens one second in every fixed window of seconds, which lets software calibrate the rate.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the fields read 00:00:00, day of week 1, date 01, month 01, year 00, century 0, and `sec_pulse` is low.
- R2: With halt low and trim 0, the seconds advance once for every REF_DIV accepted `ref_en` cycles. The new fields and a one-cycle `sec_pulse` appear at the clock edge that samples the last of those cycles.
- R3: Seconds and minutes count 00 to 59 in packed BCD (tens digit in bits 7:4, units digit in bits 3:0). A wrap to 00 carries into the next field.
- R4: Hours count 00 to 23 in packed BCD. The wrap from 23 to 00 starts a new day.
- R5: Day of week counts 1 to 7 in binary and steps on every new day, with 7 followed by 1.
- R6: The last date is 30 in months 04, 06, 09 and 11, and 31 in months 01, 03, 05, 07, 08, 10 and 12. After the last date comes date 01 of the next month.
- R7: February ends at 29 when the BCD year is a multiple of four, with year 00 counted as a leap year, and at 28 otherwise.
- R8: Month 12 is followed by month 01 and the year advances. Year 99 is followed by 00 and the binary century advances, with 255 followed by 0.
- R9: A `load` cycle writes every field at the next edge, suppresses any tick in that cycle and restarts the prescaler and the trim window. After it, a full REF_DIV accepted cycles are needed before the seconds move.
- R10: While `halt` is high, `ref_en` is ignored. The partial second is kept and resumes when halt falls.
- R11: Seconds are numbered from 0 since the last load or reset. Every CAL_PERIOD-th second (index CAL_PERIOD-1, 2*CAL_PERIOD-1, ...) lasts REF_DIV minus `cal_trim` accepted cycles, where `cal_trim` is in two's complement. All other seconds last REF_DIV.
- R12: A loaded field at or above its wrap value (for example seconds 0x75) wraps to its first value on its next increment and carries as a normal wrap would.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_en | input | 1 | One-cycle enable at the 32768 Hz reference rate |
| halt | input | 1 | Freezes the prescaler while high |
| load | input | 1 | Writes all ld_* fields and restarts the prescaler |
| cal_trim | input | CAL_W | Signed per-window trim in reference counts |
| ld_sec | input | 8 | Seconds to load, BCD |
| ld_min | input | 8 | Minutes to load, BCD |
| ld_hour | input | 8 | Hours to load, BCD |
| ld_wday | input | 3 | Day of week to load, 1 to 7 |
| ld_date | input | 8 | Day of month to load, BCD |
| ld_month | input | 8 | Month to load, BCD |
| ld_year | input | 8 | Year to load, BCD |
| ld_cent | input | 8 | Century to load, binary |
| tm_sec | output | 8 | Current seconds, BCD |
| tm_min | output | 8 | Current minutes, BCD |
| tm_hour | output | 8 | Current hours, BCD |
| tm_wday | output | 3 | Current day of week |
| tm_date | output | 8 | Current day of month, BCD |
| tm_month | output | 8 | Current month, BCD |
| tm_year | output | 8 | Current year, BCD |
| tm_cent | output | 8 | Current century, binary |
| sec_pulse | output | 1 | High for the one cycle right after the fields advanced |

## Verification
A load shows on the fields one edge after the `load` cycle. A tick is due at the same edge that samples the last reference cycle of a second, and that edge also raises `sec_pulse` for one cycle. The bench drives every input on the falling edge and reads the outputs on the following falling edge, after the rising edge that acts on them. To test the second length, it counts reference cycles one by one and checks both one count short of the expected length and exactly at it. The calendar sweep loads the last moment of every month of all hundred years, and also the day before it, and then applies one exact second.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef struct packed {
        logic [7:0] cent;
        logic [7:0] year;
        logic [7:0] month;
        logic [7:0] date;
        logic [2:0] wday;
        logic [7:0] hour;
        logic [7:0] minute;
        logic [7:0] sec;
    } rtc_time_t;

    typedef struct packed {
        rtc_time_t tm;
        logic      stepped;
    } cal_state_t;

    // Two-digit BCD increment without range limit; caller handles wrap.
    function automatic logic [7:0] bcd_next(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Multiple of four: 10*T + U = 2*T + U (mod 4).
    function automatic logic bcd_leap(input logic [7:0] y);
        logic [3:0] s;
        s = {2'b00, y[4], 1'b0} + y[3:0];
        return (s[1:0] == 2'b00);
    endfunction

    function automatic logic [7:0] month_last(input logic [7:0] m, input logic leap);
        case (m)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int REF_DIV    = 32768,
    parameter int CAL_PERIOD = 64,
    parameter int CAL_W      = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_en,
    input  logic             halt,
    input  logic             restart,
    input  logic [CAL_W-1:0] cal,
    output logic             tick
);
    localparam int CNT_W = $clog2(REF_DIV + (1 << (CAL_W - 1)) + 1);
    localparam int LW    = CNT_W + 2;
    localparam int WIN_W = (CAL_PERIOD > 1) ? $clog2(CAL_PERIOD) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [WIN_W-1:0] win;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic [LW-1:0] cal_ext;
    logic [LW-1:0] len;
    logic [LW-1:0] len_m1;
    logic          trim_sec;
    logic          step;
    logic          last;

    always_comb begin
        cal_ext  = {{(LW - CAL_W){cal[CAL_W-1]}}, cal};
        trim_sec = (st_q.win == WIN_W'(CAL_PERIOD - 1));
        len      = LW'(REF_DIV) - (trim_sec ? cal_ext : '0);
        len_m1   = len - LW'(1);
        step     = ref_en && !halt;
        last     = ({2'b00, st_q.cnt} >= len_m1);
        tick     = step && last && !restart;

        st_d = st_q;
        if (restart) begin
            st_d.cnt = '0;
            st_d.win = '0;
        end else if (step) begin
            if (last) begin
                st_d.cnt = '0;
                st_d.win = trim_sec ? '0 : st_q.win + WIN_W'(1);
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_halt_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !restart) |=> $stable(st_q));

    assert_restart_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.cnt == '0 && st_q.win == '0));

    assert_tick_needs_ref_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (ref_en && !halt));

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      load,
    input  rtc_time_t ld,
    output rtc_time_t cur,
    output logic      stepped
);
    localparam rtc_time_t TM_RESET = '{cent: 8'd0, year: 8'h00, month: 8'h01,
                                       date: 8'h01, wday: 3'd1, hour: 8'h00,
                                       minute: 8'h00, sec: 8'h00};

    cal_state_t cs_d, cs_q;
    logic [7:0] last_date;

    always_comb begin
        cs_d         = cs_q;
        cs_d.stepped = tick && !load;
        last_date    = month_last(cs_q.tm.month, bcd_leap(cs_q.tm.year));
        if (load) begin
            cs_d.tm = ld;
        end else if (tick) begin
            if (cs_q.tm.sec >= 8'h59) begin
                cs_d.tm.sec = 8'h00;
                if (cs_q.tm.minute >= 8'h59) begin
                    cs_d.tm.minute = 8'h00;
                    if (cs_q.tm.hour >= 8'h23) begin
                        cs_d.tm.hour = 8'h00;
                        cs_d.tm.wday = (cs_q.tm.wday >= 3'd7 || cs_q.tm.wday == 3'd0)
                                       ? 3'd1 : cs_q.tm.wday + 3'd1;
                        if (cs_q.tm.date >= last_date) begin
                            cs_d.tm.date = 8'h01;
                            if (cs_q.tm.month >= 8'h12) begin
                                cs_d.tm.month = 8'h01;
                                if (cs_q.tm.year >= 8'h99) begin
                                    cs_d.tm.year = 8'h00;
                                    cs_d.tm.cent = cs_q.tm.cent + 8'd1;
                                end else begin
                                    cs_d.tm.year = bcd_next(cs_q.tm.year);
                                end
                            end else begin
                                cs_d.tm.month = bcd_next(cs_q.tm.month);
                            end
                        end else begin
                            cs_d.tm.date = bcd_next(cs_q.tm.date);
                        end
                    end else begin
                        cs_d.tm.hour = bcd_next(cs_q.tm.hour);
                    end
                end else begin
                    cs_d.tm.minute = bcd_next(cs_q.tm.minute);
                end
            end else begin
                cs_d.tm.sec = bcd_next(cs_q.tm.sec);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q.tm      <= TM_RESET;
            cs_q.stepped <= 1'b0;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign cur     = cs_q.tm;
    assign stepped = cs_q.stepped;

    assert_sec_bcd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_q.stepped |-> (cs_q.tm.sec <= 8'h59 && cs_q.tm.sec[3:0] <= 4'd9));

    assert_step_moves_sec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_q.stepped |-> (cs_q.tm.sec != $past(cs_q.tm.sec)));

    assert_newday_fields_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_q.stepped && cs_q.tm.hour == 8'h00 && cs_q.tm.minute == 8'h00 && cs_q.tm.sec == 8'h00)
        |-> (cs_q.tm.wday >= 3'd1 && cs_q.tm.wday <= 3'd7
             && cs_q.tm.date >= 8'h01 && cs_q.tm.date <= 8'h31 && cs_q.tm.date[3:0] <= 4'd9));

    assert_hour_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_q.stepped && $past(cs_q.tm.hour) <= 8'h23) |-> (cs_q.tm.hour <= 8'h23));

    assert_load_applies_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cs_q.tm == $past(ld) && !cs_q.stepped));

endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
    import rtc_pkg::*;
#(
    parameter int REF_DIV    = 32768,
    parameter int CAL_PERIOD = 64,
    parameter int CAL_W      = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_en,
    input  logic             halt,
    input  logic             load,
    input  logic [CAL_W-1:0] cal_trim,
    input  logic [7:0]       ld_sec,
    input  logic [7:0]       ld_min,
    input  logic [7:0]       ld_hour,
    input  logic [2:0]       ld_wday,
    input  logic [7:0]       ld_date,
    input  logic [7:0]       ld_month,
    input  logic [7:0]       ld_year,
    input  logic [7:0]       ld_cent,
    output logic [7:0]       tm_sec,
    output logic [7:0]       tm_min,
    output logic [7:0]       tm_hour,
    output logic [2:0]       tm_wday,
    output logic [7:0]       tm_date,
    output logic [7:0]       tm_month,
    output logic [7:0]       tm_year,
    output logic [7:0]       tm_cent,
    output logic             sec_pulse
);
    logic      tick;
    rtc_time_t ld_tm;
    rtc_time_t cur_tm;

    always_comb begin
        ld_tm.cent   = ld_cent;
        ld_tm.year   = ld_year;
        ld_tm.month  = ld_month;
        ld_tm.date   = ld_date;
        ld_tm.wday   = ld_wday;
        ld_tm.hour   = ld_hour;
        ld_tm.minute = ld_min;
        ld_tm.sec    = ld_sec;
    end

    rtc_prescaler #(
        .REF_DIV    (REF_DIV),
        .CAL_PERIOD (CAL_PERIOD),
        .CAL_W      (CAL_W)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_en  (ref_en),
        .halt    (halt),
        .restart (load),
        .cal     (cal_trim),
        .tick    (tick)
    );

    rtc_calendar u_cal (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .load    (load),
        .ld      (ld_tm),
        .cur     (cur_tm),
        .stepped (sec_pulse)
    );

    assign tm_sec   = cur_tm.sec;
    assign tm_min   = cur_tm.minute;
    assign tm_hour  = cur_tm.hour;
    assign tm_wday  = cur_tm.wday;
    assign tm_date  = cur_tm.date;
    assign tm_month = cur_tm.month;
    assign tm_year  = cur_tm.year;
    assign tm_cent  = cur_tm.cent;

    assert_pulse_only_on_ref_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |-> ($past(ref_en) && !$past(halt) && !$past(load)));

endmodule

// File: tb/sim_rtc_bcd_calendar.sv
module sim_rtc_bcd_calendar;
    localparam int RD = 20;
    localparam int CP = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_en = 1'b0, halt = 1'b0, load = 1'b0;
    logic [4:0] cal_trim = 5'd0;
    logic [7:0] ld_sec = 0, ld_min = 0, ld_hour = 0, ld_date = 0, ld_month = 0, ld_year = 0, ld_cent = 0;
    logic [2:0] ld_wday = 0;
    logic [7:0] tm_sec, tm_min, tm_hour, tm_date, tm_month, tm_year, tm_cent;
    logic [2:0] tm_wday;
    logic       sec_pulse;

    int vectors = 0;
    int miscompares = 0;

    always #5 clk = ~clk;

    rtc_bcd_calendar #(.REF_DIV(RD), .CAL_PERIOD(CP), .CAL_W(5)) u0 (
        .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .halt(halt), .load(load),
        .cal_trim(cal_trim), .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour),
        .ld_wday(ld_wday), .ld_date(ld_date), .ld_month(ld_month), .ld_year(ld_year),
        .ld_cent(ld_cent), .tm_sec(tm_sec), .tm_min(tm_min), .tm_hour(tm_hour),
        .tm_wday(tm_wday), .tm_date(tm_date), .tm_month(tm_month), .tm_year(tm_year),
        .tm_cent(tm_cent), .sec_pulse(sec_pulse)
    );

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int mdays(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    function automatic logic [58:0] pk(input int c, input int y, input int mo, input int d,
                                       input int w, input int h, input int mi, input int s);
        return {8'(c), bcd(y), bcd(mo), bcd(d), 3'(w), bcd(h), bcd(mi), bcd(s)};
    endfunction

    function automatic logic [58:0] now();
        return {tm_cent, tm_year, tm_month, tm_date, tm_wday, tm_hour, tm_min, tm_sec};
    endfunction

    task automatic chk(input string req, input logic [58:0] act, input logic [58:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ref_en = 1'b1;
        end
        @(negedge clk) ref_en = 1'b0;
    endtask

    task automatic do_load(input logic [7:0] c, input logic [7:0] y, input logic [7:0] mo,
                           input logic [7:0] d, input logic [2:0] w, input logic [7:0] h,
                           input logic [7:0] mi, input logic [7:0] s);
        @(negedge clk);
        ld_cent = c; ld_year = y; ld_month = mo; ld_date = d;
        ld_wday = w; ld_hour = h; ld_min = mi; ld_sec = s;
        load = 1'b1;
        @(negedge clk) load = 1'b0;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", now(), pk(0, 0, 1, 1, 1, 0, 0, 0));
        chk("R1 pulse", 59'(sec_pulse), 59'(0));

        // R2 second length and pulse timing
        do_load(8'd20, 8'h24, 8'h06, 8'h15, 3'd3, 8'h10, 8'h14, 8'h30);
        pulses(RD - 1);
        chk("R2 early", now(), pk(20, 24, 6, 15, 3, 10, 14, 30));
        chk("R2 nopulse", 59'(sec_pulse), 59'(0));
        pulses(1);
        chk("R2 tick", now(), pk(20, 24, 6, 15, 3, 10, 14, 31));
        chk("R2 pulse", 59'(sec_pulse), 59'(1));
        @(negedge clk);
        chk("R2 pulse width", 59'(sec_pulse), 59'(0));

        // R3 minute carry, R4 hour carry
        do_load(8'd20, 8'h24, 8'h06, 8'h15, 3'd3, 8'h10, 8'h14, 8'h59);
        pulses(RD);
        chk("R3", now(), pk(20, 24, 6, 15, 3, 10, 15, 0));
        do_load(8'd20, 8'h24, 8'h06, 8'h15, 3'd3, 8'h19, 8'h59, 8'h59);
        pulses(RD);
        chk("R4", now(), pk(20, 24, 6, 15, 3, 20, 0, 0));

        // R5 weekday 7 -> 1
        do_load(8'd20, 8'h24, 8'h06, 8'h15, 3'd7, 8'h23, 8'h59, 8'h59);
        pulses(RD);
        chk("R5", now(), pk(20, 24, 6, 16, 1, 0, 0, 0));

        // R9 load wins over a tick in the same cycle, then full second needed
        do_load(8'd20, 8'h24, 8'h06, 8'h15, 3'd3, 8'h08, 8'h00, 8'h00);
        pulses(RD - 1);
        @(negedge clk);
        ld_sec = 8'h40; ld_min = 8'h41; ld_hour = 8'h12;
        load = 1'b1; ref_en = 1'b1;
        @(negedge clk) begin load = 1'b0; ref_en = 1'b0; end
        chk("R9 load", now(), pk(20, 24, 6, 15, 3, 12, 41, 40));
        chk("R9 no pulse", 59'(sec_pulse), 59'(0));
        pulses(RD - 1);
        chk("R9 restart", now(), pk(20, 24, 6, 15, 3, 12, 41, 40));
        pulses(1);
        chk("R9 full", now(), pk(20, 24, 6, 15, 3, 12, 41, 41));

        // R10 halt keeps partial second
        do_load(8'd20, 8'h24, 8'h06, 8'h15, 3'd3, 8'h08, 8'h00, 8'h00);
        pulses(10);
        halt = 1'b1;
        pulses(3 * RD);
        chk("R10 frozen", now(), pk(20, 24, 6, 15, 3, 8, 0, 0));
        halt = 1'b0;
        pulses(RD - 11);
        chk("R10 partial", now(), pk(20, 24, 6, 15, 3, 8, 0, 0));
        pulses(1);
        chk("R10 resume", now(), pk(20, 24, 6, 15, 3, 8, 0, 1));

        // R11 positive and negative trim on every CP-th second
        cal_trim = 5'd3;
        do_load(8'd20, 8'h24, 8'h06, 8'h15, 3'd3, 8'h08, 8'h00, 8'h00);
        pulses((CP - 1) * RD);
        chk("R11 plain", now(), pk(20, 24, 6, 15, 3, 8, 0, CP - 1));
        pulses(RD - 3 - 1);
        chk("R11 short-1", now(), pk(20, 24, 6, 15, 3, 8, 0, CP - 1));
        pulses(1);
        chk("R11 short", now(), pk(20, 24, 6, 15, 3, 8, 0, CP));
        pulses(RD - 1);
        chk("R11 next plain", now(), pk(20, 24, 6, 15, 3, 8, 0, CP));
        pulses(1);
        chk("R11 next", now(), pk(20, 24, 6, 15, 3, 8, 0, CP + 1));
        cal_trim = 5'b11110;
        do_load(8'd20, 8'h24, 8'h06, 8'h15, 3'd3, 8'h08, 8'h00, 8'h00);
        pulses((CP - 1) * RD + RD + 2 - 1);
        chk("R11 long-1", now(), pk(20, 24, 6, 15, 3, 8, 0, CP - 1));
        pulses(1);
        chk("R11 long", now(), pk(20, 24, 6, 15, 3, 8, 0, CP));
        cal_trim = 5'd0;

        // R8 century wrap 255 -> 0
        do_load(8'd255, 8'h99, 8'h12, 8'h31, 3'd2, 8'h23, 8'h59, 8'h59);
        pulses(RD);
        chk("R8 century", now(), pk(0, 0, 1, 1, 3, 0, 0, 0));

        // R12 out-of-range loaded seconds and weekday
        do_load(8'd20, 8'h24, 8'h06, 8'h15, 3'd3, 8'h08, 8'h10, 8'h75);
        pulses(RD);
        chk("R12 sec", now(), pk(20, 24, 6, 15, 3, 8, 11, 0));
        do_load(8'd20, 8'h24, 8'h04, 8'h31, 3'd0, 8'h23, 8'h59, 8'h59);
        pulses(RD);
        chk("R12 date", now(), pk(20, 24, 5, 1, 1, 0, 0, 0));

        // R6 R7 R8 sweep: every month of every year, last day and the day before
        for (int y = 0; y < 100; y++) begin
            for (int m = 1; m <= 12; m++) begin
                int l, w, ny, nm, nc;
                l  = mdays(m, y);
                w  = ((y * 12 + m) % 7) + 1;
                nm = (m == 12) ? 1 : m + 1;
                ny = (m == 12) ? (y + 1) % 100 : y;
                nc = (m == 12 && y == 99) ? 21 : 20;
                do_load(8'd20, bcd(y), bcd(m), bcd(l - 1), 3'(w), 8'h23, 8'h59, 8'h59);
                pulses(RD);
                chk((m == 2) ? "R7 penultimate" : "R6 penultimate", now(),
                    pk(20, y, m, l, (w == 7) ? 1 : w + 1, 0, 0, 0));
                do_load(8'd20, bcd(y), bcd(m), bcd(l), 3'(w), 8'h23, 8'h59, 8'h59);
                pulses(RD);
                chk((m == 12) ? "R8 year" : ((m == 2) ? "R7 leap" : "R6 month"), now(),
                    pk(nc, ny, nm, 1, (w == 7) ? 1 : w + 1, 0, 0, 0));
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule